// File: doc/BRIEF.md
# Interrupt Mapping and Clear Controller

The block is a register-mapped interrupt router. It takes 48 level-sensitive interrupt request lines and drives 48 registered vector outputs. Lines 0 to 31 come from expansion-bus slots. Lines 32 to 47 come from on-board peripherals. Each line is gated by the enable bit of the mapping register that governs it. A mapping register also returns a fixed interrupt number, so software can identify the source. Eight slot mapping registers each govern four consecutive slot lines. Thirty-two peripheral mapping registers each govern at most one peripheral line.

Software reaches the block over a simple 32-bit register port, with a byte address, a write enable, write data and combinational read data. Every register sits in an 8-byte slot, and only the upper word of a slot (address bit 2 set) is live. Writing the upper word of a clear slot drops the matching vector output for one cycle. After that cycle the output takes the input level again, so a request that is still held returns on the following cycle.

Address layout: bits [9:8] select the region, bits [7:3] select the slot and bit 2 selects the word. Any bit above bit 9 that is set addresses nothing. The regions are:
- 0x000, slot mapping registers (slots 0–7)
- 0x100, peripheral mapping registers (slots 0–31)
- 0x200, slot-line clear strobes (slots 0–31)
- 0x300, peripheral-line clear strobes (slots 0–15)

Top module: `irq_map_ctrl`

## Requirements
- R1: An active-low asynchronous reset (`rst_ni` low) clears the enable bit (bit 31) of every mapping register and drives all vector outputs low at once. After reset, slot mapping register i reads 0x7C0|(i<<2) and peripheral mapping register i reads 0x7E0+i.
- R2: Bits 30:0 of every mapping register are read-only and hold its interrupt number. A write changes only bit 31.
- R3: A write to the upper word of a mapping slot (address bit 2 = 1) loads bit 31 from `wdata_i[31]`. A write to the lower word (bit 2 = 0) changes nothing, and a read of the lower word returns 0.
- R4: Slot line n (0–31) is gated by slot mapping register n>>2. Peripheral line 32+m is gated by peripheral mapping register m.
- R5: While the governing enable bit is 0, the vector output is low whatever the input level. A cleared enable takes effect on the output one cycle after the writing edge.
- R6: While the governing enable bit is 1, the vector output equals the input level of the previous clock edge.
- R7: Writing the upper word of slot-clear slot n forces output n low for one cycle, and peripheral-clear slot m does the same for output 32+m. The output then follows the input again, so an input that is still high raises it in the next cycle. Lower-word clear writes are ignored.
- R8: Addresses with any bit above bit 9 set, and slots beyond the populated count (slot mapping slots 8 or higher, peripheral-clear slots 16 or higher), read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write enable |
| addr_i | input | 12 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_i | input | 48 | Level interrupt requests |
| vec_o | output | 48 | Gated, registered vector outputs |

## Verification
A wrong enable bit shows at the port in two ways. It appears on `vec_o` one edge after the input is sampled, and it appears at once in bit 31 of the register readback. The bench holds requests high while it toggles enables, so a stuck or cross-wired enable appears within two cycles on the wrong group of four slot lines. A decode fault shows as a clear strobe that lowers the wrong output for exactly one cycle. It can also show as a lower-word or out-of-range write that changes an enable, which then appears on the next readback of the neighbouring slot.

// File: rtl/irq_map_pkg.sv
`timescale 1ns/1ps
package irq_map_pkg;
  localparam int SLOT_W = 5;
  localparam int REG_W  = 32;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_PCI_MAP,
    SEL_AUX_MAP,
    SEL_PCI_CLR,
    SEL_AUX_CLR
  } sel_e;

  // fixed interrupt numbers held in bits 30:0
  function automatic logic [REG_W-2:0] slot_map_num(int i);
    return 31'(32'h7C0 | (i << 2));
  endfunction

  function automatic logic [REG_W-2:0] aux_map_num(int i);
    return 31'(32'h7E0 + i);
  endfunction
endpackage

// File: rtl/irq_reg_decode.sv
`timescale 1ns/1ps
module irq_reg_decode
  import irq_map_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int PCI_MAPS  = 8,
  parameter int AUX_MAPS  = 32,
  parameter int PCI_LINES = 32,
  parameter int AUX_LINES = 16
) (
  input  logic [ADDR_W-1:0] addr_i,
  output sel_e              sel_o,
  output logic [SLOT_W-1:0] slot_o
);
  localparam int REGION_LSB = SLOT_W + 3;

  logic [1:0] region;
  logic       in_window;
  logic       unused_lsb;

  assign region     = addr_i[REGION_LSB+1:REGION_LSB];
  assign slot_o     = addr_i[REGION_LSB-1:3];
  assign in_window  = (addr_i[ADDR_W-1:REGION_LSB+2] == '0);
  assign unused_lsb = ^addr_i[1:0];

  always_comb begin
    sel_o = SEL_NONE;
    if (in_window && addr_i[2]) begin
      unique case (region)
        2'd0: if (int'(slot_o) < PCI_MAPS)  sel_o = SEL_PCI_MAP;
        2'd1: if (int'(slot_o) < AUX_MAPS)  sel_o = SEL_AUX_MAP;
        2'd2: if (int'(slot_o) < PCI_LINES) sel_o = SEL_PCI_CLR;
        default: if (int'(slot_o) < AUX_LINES) sel_o = SEL_AUX_CLR;
      endcase
    end
  end
endmodule

// File: rtl/irq_map_bank.sv
`timescale 1ns/1ps
module irq_map_bank
  import irq_map_pkg::*;
#(
  parameter int N      = 8,
  parameter bit IS_AUX = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic              wbit_i,
  output logic [N-1:0]      en_o,
  output logic [REG_W-1:0]  rd_o
);
  logic [N-1:0] en_q;

  for (genvar i = 0; i < N; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) en_q[i] <= 1'b0;
      else if (wr_i && slot_i == SLOT_W'(i)) en_q[i] <= wbit_i;
    end
  end

  always_comb begin
    rd_o = '0;
    for (int i = 0; i < N; i++) begin
      if (slot_i == SLOT_W'(i))
        rd_o = {en_q[i], IS_AUX ? aux_map_num(i) : slot_map_num(i)};
    end
  end

  assign en_o = en_q;
endmodule

// File: rtl/irq_gate.sv
`timescale 1ns/1ps
module irq_gate #(
  parameter int N = 48
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] irq_i,
  input  logic [N-1:0] en_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] vec_o
);
  logic [N-1:0] vec_q;

  // clear wins for exactly one sample, then the level is taken again
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vec_q <= '0;
    else         vec_q <= irq_i & en_i & ~clr_i;
  end

  assign vec_o = vec_q;
endmodule

// File: rtl/irq_map_ctrl.sv
`timescale 1ns/1ps
module irq_map_ctrl
  import irq_map_pkg::*;
#(
  parameter int ADDR_W        = 12,
  parameter int PCI_MAPS      = 8,
  parameter int LINES_PER_MAP = 4,
  parameter int AUX_MAPS      = 32,
  parameter int AUX_LINES     = 16
) (
  input  logic                                        clk_i,
  input  logic                                        rst_ni,
  input  logic                                        we_i,
  input  logic [ADDR_W-1:0]                           addr_i,
  input  logic [REG_W-1:0]                            wdata_i,
  output logic [REG_W-1:0]                            rdata_o,
  input  logic [PCI_MAPS*LINES_PER_MAP+AUX_LINES-1:0] irq_i,
  output logic [PCI_MAPS*LINES_PER_MAP+AUX_LINES-1:0] vec_o
);
  localparam int PCI_LINES = PCI_MAPS * LINES_PER_MAP;
  localparam int N_OUT     = PCI_LINES + AUX_LINES;

  sel_e              sel;
  logic [SLOT_W-1:0] slot;
  logic [PCI_MAPS-1:0] pci_en;
  logic [AUX_MAPS-1:0] aux_en;
  logic [REG_W-1:0]  pci_rd, aux_rd;
  logic [N_OUT-1:0]  line_en, clr_vec;
  logic              unused_wdata;

  assign unused_wdata = ^wdata_i[REG_W-2:0];

  irq_reg_decode #(
    .ADDR_W(ADDR_W), .PCI_MAPS(PCI_MAPS), .AUX_MAPS(AUX_MAPS),
    .PCI_LINES(PCI_LINES), .AUX_LINES(AUX_LINES)
  ) u_dec (
    .addr_i(addr_i), .sel_o(sel), .slot_o(slot)
  );

  irq_map_bank #(.N(PCI_MAPS), .IS_AUX(1'b0)) u_pci_bank (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_i(we_i && sel == SEL_PCI_MAP), .slot_i(slot),
    .wbit_i(wdata_i[REG_W-1]), .en_o(pci_en), .rd_o(pci_rd)
  );

  irq_map_bank #(.N(AUX_MAPS), .IS_AUX(1'b1)) u_aux_bank (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_i(we_i && sel == SEL_AUX_MAP), .slot_i(slot),
    .wbit_i(wdata_i[REG_W-1]), .en_o(aux_en), .rd_o(aux_rd)
  );

  // per-line routing of enables and clear strobes
  for (genvar i = 0; i < N_OUT; i++) begin : g_line
    if (i < PCI_LINES) begin : g_pci
      assign line_en[i] = pci_en[i / LINES_PER_MAP];
      assign clr_vec[i] = we_i && sel == SEL_PCI_CLR && slot == SLOT_W'(i);
    end else begin : g_aux
      assign line_en[i] = aux_en[i - PCI_LINES];
      assign clr_vec[i] = we_i && sel == SEL_AUX_CLR && slot == SLOT_W'(i - PCI_LINES);
    end
  end

  if (AUX_MAPS > AUX_LINES) begin : g_spare
    logic unused_spare;
    assign unused_spare = ^aux_en[AUX_MAPS-1:AUX_LINES];
  end

  irq_gate #(.N(N_OUT)) u_gate (
    .clk_i(clk_i), .rst_ni(rst_ni), .irq_i(irq_i),
    .en_i(line_en), .clr_i(clr_vec), .vec_o(vec_o)
  );

  always_comb begin
    unique case (sel)
      SEL_PCI_MAP: rdata_o = pci_rd;
      SEL_AUX_MAP: rdata_o = aux_rd;
      default:     rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_map_ctrl_chk.sv
`timescale 1ns/1ps
module irq_map_ctrl_chk #(
  parameter int ADDR_W = 12,
  parameter int N_OUT  = 48,
  parameter int N_EN   = 40
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       rdata_o,
  input logic [N_OUT-1:0]  irq_i,
  input logic [N_OUT-1:0]  vec_o,
  input logic [N_OUT-1:0]  line_en,
  input logic [N_OUT-1:0]  clr_vec,
  input logic [N_EN-1:0]   en_all
);
  a_r5_disabled_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((vec_o & ~$past(line_en)) == '0));

  a_r6_follows_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (((vec_o ^ $past(irq_i)) & $past(line_en & ~clr_vec)) == '0));

  a_r7_clear_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((vec_o & $past(clr_vec)) == '0));

  a_r7_single_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(clr_vec));

  a_r3_enables_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(en_all));

  a_r3_lower_word_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_i[2] |-> (rdata_o == '0));

  a_r8_outside_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[ADDR_W-1:10] != '0) |-> (rdata_o == '0));
endmodule

bind irq_map_ctrl irq_map_ctrl_chk #(
  .ADDR_W(ADDR_W), .N_OUT(N_OUT), .N_EN(PCI_MAPS + AUX_MAPS)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
  .rdata_o(rdata_o), .irq_i(irq_i), .vec_o(vec_o),
  .line_en(line_en), .clr_vec(clr_vec), .en_all({aux_en, pci_en})
);

// File: tb/irq_map_ctrl_bench.sv
`timescale 1ns/1ps
module irq_map_ctrl_bench;
  localparam int N_OUT = 48;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic        we;
  logic [11:0] addr;
  logic [31:0] wdata, rdata;
  logic [N_OUT-1:0] irq, vec;

  always #2.5 clk = ~clk;

  irq_map_ctrl u_irq_map_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_i(irq), .vec_o(vec)
  );

  typedef struct {
    int               due;
    bit               is_rd;
    logic [N_OUT-1:0] exp;
    string            tag;
  } item_t;

  item_t sbq[$];
  int    cyc = 0;
  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  logic [7:0]  m_pci;
  logic [31:0] m_aux;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare every item that falls due in this cycle
  always @(negedge clk) begin
    for (int k = sbq.size() - 1; k >= 0; k--) begin
      if (sbq[k].due == cyc) begin
        logic [N_OUT-1:0] act;
        act = sbq[k].is_rd ? {16'b0, rdata} : vec;
        checks++;
        if (act !== sbq[k].exp) begin
          errors++;
          $display("FAIL %s: actual=%h expected=%h", sbq[k].tag, act, sbq[k].exp);
        end
        sbq.delete(k);
      end
    end
  end

  function automatic logic [N_OUT-1:0] model_vec();
    logic [N_OUT-1:0] v;
    for (int i = 0; i < N_OUT; i++)
      v[i] = irq[i] & ((i < 32) ? m_pci[i >> 2] : m_aux[i - 32]);
    return v;
  endfunction

  task automatic tick(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic push_vec(int delay, logic [N_OUT-1:0] exp, string tag);
    item_t it;
    it.due = cyc + delay; it.is_rd = 1'b0; it.exp = exp; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic rd(logic [11:0] a, logic [31:0] exp, string tag);
    item_t it;
    addr = a;
    it.due = cyc; it.is_rd = 1'b1; it.exp = {16'b0, exp}; it.tag = tag;
    sbq.push_back(it);
    tick();
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    tick();
    we = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic set_irq(logic [N_OUT-1:0] v, string tag);
    irq = v;
    push_vec(1, model_vec(), tag);
    tick(3);
  endtask

  initial begin
    rst_ni = 1'b0; we = 1'b0; addr = '0; wdata = '0; irq = '1;
    m_pci = '0; m_aux = '0;
    tick(3);
    push_vec(0, '0, "R1 outputs low in reset");
    tick();
    rst_ni = 1'b1;
    tick();

    for (int i = 0; i < 8; i++)
      rd(12'(i * 8 + 4), 32'h7C0 | 32'(i << 2), "R1 slot map reset value");
    for (int i = 0; i < 32; i++)
      rd(12'(12'h104 + i * 8), 32'h7E0 + 32'(i), "R1 aux map reset value");
    rd(12'h000, 32'h0, "R3 lower word reads 0");
    rd(12'h108, 32'h0, "R3 lower word reads 0 aux");
    push_vec(0, '0, "R5 all disabled, inputs high");
    tick(2);

    // enable slot map 2 -> lines 8..11
    wr(12'h014, 32'hFFFF_FFFF); m_pci[2] = 1'b1;
    push_vec(1, model_vec(), "R4 R6 slot map 2 gates lines 8-11");
    tick(3);
    rd(12'h014, 32'h8000_07C8, "R2 only bit31 written");

    wr(12'h010, 32'h0);
    tick(2);
    rd(12'h014, 32'h8000_07C8, "R3 lower word write ignored");
    push_vec(0, model_vec(), "R3 lower word write no output effect");
    tick(2);

    // peripheral map 5 -> line 37
    wr(12'h12C, 32'h8000_0000); m_aux[5] = 1'b1;
    push_vec(1, model_vec(), "R4 aux map 5 gates line 37");
    tick(3);
    rd(12'h12C, 32'h8000_07E5, "R2 aux readback");

    set_irq(48'h5A5A_C3C3_0F0F, "R6 pattern A");
    set_irq(48'hA5A5_3C3C_F0F0, "R6 pattern B");
    set_irq(48'h0000_0000_0000, "R6 all low");
    set_irq(48'hFFFF_FFFF_FFFF, "R6 all high");

    wr(12'h014, 32'h7FFF_FFFF); m_pci[2] = 1'b0;
    push_vec(1, model_vec(), "R5 disable drops lines 8-11");
    tick(3);
    rd(12'h014, 32'h0000_07C8, "R2 bits 30:0 unchanged");

    // clear strobes
    wr(12'h014, 32'h8000_0000); m_pci[2] = 1'b1;
    tick(3);
    wr(12'h24C, 32'h0);
    push_vec(0, model_vec() & ~(48'd1 << 9), "R7 slot clear lowers line 9");
    push_vec(1, model_vec(), "R7 held input reasserts line 9");
    tick(3);
    wr(12'h32C, 32'h0);
    push_vec(0, model_vec() & ~(48'd1 << 37), "R7 aux clear lowers line 37");
    push_vec(1, model_vec(), "R7 held input reasserts line 37");
    tick(3);
    wr(12'h248, 32'h0);
    push_vec(0, model_vec(), "R7 lower word clear ignored");
    tick(3);

    // unmapped space
    wr(12'h404, 32'hFFFF_FFFF);
    push_vec(1, model_vec(), "R8 write above window no effect");
    tick(3);
    rd(12'h404, 32'h0, "R8 read above window");
    wr(12'h044, 32'hFFFF_FFFF);
    push_vec(1, model_vec(), "R8 slot map 8 absent");
    tick(3);
    rd(12'h044, 32'h0, "R8 read absent slot map");
    rd(12'h03C, 32'h0000_07DC, "R8 no alias onto slot map 7");
    wr(12'h384, 32'h0);
    push_vec(0, model_vec(), "R8 aux clear slot 16 absent");
    tick(3);

    // asynchronous reset mid-run
    rst_ni = 1'b0; m_pci = '0; m_aux = '0;
    push_vec(0, '0, "R1 async reset drops outputs");
    tick();
    rst_ni = 1'b1;
    tick();
    rd(12'h014, 32'h0000_07C8, "R1 slot enable cleared");
    rd(12'h12C, 32'h0000_07E5, "R1 aux enable cleared");
    push_vec(1, '0, "R1 outputs stay low after reset");
    tick(4);

    if (sbq.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard: actual=%0d expected=0 items left", sbq.size());
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R1-flow: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule